// File: doc/BRIEF.md
# Two-Phase Key Match Engine

This block is the synchronous lookup side of a small content-addressable table. A key arrives on a 32-bit bus. A rising start strobe launches a lookup, and a fixed number of cycles later the engine reports the result. It raises a one-cycle completion pulse after every lookup. On a hit it also raises a found flag with that pulse. When ATM mode is on and the winning entry is a path-level entry, it raises a path flag as well. The 16-bit result stays in a register and appears on the data output only while the output enable is high.

Keys may be 64 bits wide. In that case a separate low-half strobe captures the lower 32 bits from the bus first, and the start strobe then provides the upper 32 bits. A load port writes entries into the table. If the new key equals a stored key, the load overwrites that entry, so no two entries can ever hold the same key.

Top module: `keymatch_engine`

## Requirements
- R1: With `wide_mode`=0, the key is the bus value at the accepting edge, and only bits [31:0] of each stored key take part in the comparison.
- R2: With `wide_mode`=1, `low_latch` high at an edge stores the bus as key bits [31:0]. The bus value at the accepting edge forms bits [63:32], and all 64 bits are compared.
- R3: `match_done` is a single-cycle pulse. It is seen exactly LAT clock edges after the accepting edge, for hits and for misses alike.
- R4: `match_found` is high with `match_done` only on a hit. The result register then takes the hit entry's data. On a miss it takes zero.
- R5: `match_vpath` is high with `match_found` only when `atm_mode`=1 and the winning entry's path bit is set.
- R6: `match_data` shows the result register while `out_en`=1 and zero while `out_en`=0. The result register changes only at completion.
- R7: A load whose key equals a valid entry's key over all 64 bits replaces that entry. Any other load fills the lowest free slot. A load into a full table is ignored.
- R8: A lookup is accepted only on a 0-to-1 transition of `start` while no lookup is in progress. A strobe held for two cycles starts one lookup, and a strobe during a lookup is ignored.
- R9: When several entries hit, the entry with the lowest index supplies the result and the path bit.
- R10: Reset empties the table and clears every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mq_bus | input | 32 | Key bus |
| low_latch | input | 1 | Captures the lower key half (wide mode) |
| start | input | 1 | Lookup start strobe (rising edge) |
| wide_mode | input | 1 | 1: 64-bit keys, 0: 32-bit keys |
| atm_mode | input | 1 | Enables the path flag |
| out_en | input | 1 | Output enable for result data |
| ld_en | input | 1 | Entry load strobe |
| ld_key | input | 64 | Key of the loaded entry |
| ld_vpath | input | 1 | Path bit of the loaded entry |
| ld_data | input | 16 | Result data of the loaded entry |
| match_done | output | 1 | Completion pulse |
| match_found | output | 1 | Hit flag, valid with completion |
| match_vpath | output | 1 | Path-entry hit flag |
| match_data | output | 16 | Gated result data |

## Verification
The assertions check four things on every cycle. Completion never lasts two cycles. Found never appears without completion, and the path flag never appears without found. The busy counter counts down and is never reloaded mid-lookup. Stored keys stay unique, and the output data holds steady between completions. The scenarios cover what only a reference table can show: the exact latency, which entry wins a multiple hit, how the two key halves are assembled in wide mode, replacement on an equal key, the full-table drop, and whether a strobe held for two cycles or repeated while busy yields exactly one completion.

// File: rtl/kmatch_pkg.sv
package kmatch_pkg;
    localparam int BUS_W  = 32;
    localparam int KEY_W  = 2 * BUS_W;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic              valid;
        logic              vpath;
        logic [KEY_W-1:0]  key;
        logic [DATA_W-1:0] data;
    } entry_t;

    typedef struct packed {
        logic              found;
        logic              vpath;
        logic [DATA_W-1:0] data;
    } result_t;

    // narrow keys compare only the lower bus-width half
    function automatic logic key_eq(input logic [KEY_W-1:0] a,
                                    input logic [KEY_W-1:0] b,
                                    input logic wide);
        logic [KEY_W-1:0] m;
        m = wide ? {KEY_W{1'b1}} : {{BUS_W{1'b0}}, {BUS_W{1'b1}}};
        return ((a ^ b) & m) == '0;
    endfunction
endpackage

// File: rtl/kmatch_capture.sv
module kmatch_capture
    import kmatch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] bus,
    input  logic             low_stb,
    input  logic             start_stb,
    input  logic             wide,
    input  logic             idle,
    output logic             accept,
    output logic [KEY_W-1:0] key_q,
    output logic             wide_q
);
    logic [BUS_W-1:0] low_q;
    logic             start_d;

    assign accept = start_stb && !start_d && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q   <= '0;
            start_d <= 1'b0;
            key_q   <= '0;
            wide_q  <= 1'b0;
        end else begin
            start_d <= start_stb;
            if (low_stb) low_q <= bus;
            if (accept) begin
                key_q  <= wide ? {bus, low_q} : {{BUS_W{1'b0}}, bus};
                wide_q <= wide;
            end
        end
    end
endmodule

// File: rtl/kmatch_table.sv
module kmatch_table
    import kmatch_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [KEY_W-1:0]  ld_key,
    input  logic              ld_vpath,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [KEY_W-1:0]  srch_key,
    input  logic              srch_wide,
    output logic              hit,
    output logic              hit_vpath,
    output logic [DATA_W-1:0] hit_data
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    entry_t           tbl [DEPTH];
    logic [DEPTH-1:0] dup_v, free_v, hit_v;
    logic [IDX_W-1:0] wr_idx, hit_idx;
    logic             wr_ok;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign dup_v[g]  = tbl[g].valid && (tbl[g].key == ld_key);
        assign free_v[g] = !tbl[g].valid;
        assign hit_v[g]  = tbl[g].valid && key_eq(tbl[g].key, srch_key, srch_wide);
    end

    // write slot: an equal key wins over the lowest free slot
    always_comb begin
        wr_ok  = 1'b0;
        wr_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_v[i]) begin
                wr_idx = IDX_W'(i);
                wr_ok  = 1'b1;
            end
        end
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (dup_v[i]) begin
                wr_idx = IDX_W'(i);
                wr_ok  = 1'b1;
            end
        end
    end

    // lowest index hit wins
    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_v[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit       = |hit_v;
    assign hit_vpath = tbl[hit_idx].vpath;
    assign hit_data  = tbl[hit_idx].data;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
        end else if (ld_en && wr_ok) begin
            tbl[wr_idx] <= '{valid: 1'b1, vpath: ld_vpath, key: ld_key, data: ld_data};
        end
    end

    for (genvar a = 0; a < DEPTH; a++) begin : g_ua
        for (genvar b = a + 1; b < DEPTH; b++) begin : g_ub
            p_unique_keys_r7: assert property (@(posedge clk) disable iff (rst)
                !(tbl[a].valid && tbl[b].valid && (tbl[a].key == tbl[b].key)));
        end
    end
endmodule

// File: rtl/kmatch_seq.sv
module kmatch_seq
    import kmatch_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              hit,
    input  logic              hit_vpath,
    input  logic [DATA_W-1:0] hit_data,
    input  logic              atm,
    input  logic              oe,
    output logic              idle,
    output logic              done,
    output logic              found,
    output logic              vpath,
    output logic [DATA_W-1:0] out_data
);
    localparam int CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt;
    result_t          res_q;

    assign idle     = (cnt == '0);
    assign found    = res_q.found;
    assign vpath    = res_q.vpath;
    assign out_data = oe ? res_q.data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            done  <= 1'b0;
            res_q <= '0;
        end else begin
            done        <= 1'b0;
            res_q.found <= 1'b0;
            res_q.vpath <= 1'b0;
            if (accept)        cnt <= CNT_W'(LAT);
            else if (!idle)    cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
                done        <= 1'b1;
                res_q.found <= hit;
                res_q.vpath <= hit && hit_vpath && atm;
                res_q.data  <= hit ? hit_data : '0;
            end
        end
    end

    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_found_needs_done_r4: assert property (@(posedge clk) disable iff (rst)
        found |-> done);
    p_vpath_needs_found_r5: assert property (@(posedge clk) disable iff (rst)
        vpath |-> found);
    p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ($stable(oe) && !done) |-> $stable(out_data));
    p_busy_no_reload_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/keymatch_engine.sv
module keymatch_engine
    import kmatch_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LAT   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  mq_bus,
    input  logic              low_latch,
    input  logic              start,
    input  logic              wide_mode,
    input  logic              atm_mode,
    input  logic              out_en,
    input  logic              ld_en,
    input  logic [KEY_W-1:0]  ld_key,
    input  logic              ld_vpath,
    input  logic [DATA_W-1:0] ld_data,
    output logic              match_done,
    output logic              match_found,
    output logic              match_vpath,
    output logic [DATA_W-1:0] match_data
);
    logic              accept, idle, wide_q, hit, hit_vpath;
    logic [KEY_W-1:0]  key_q;
    logic [DATA_W-1:0] hit_data;

    kmatch_capture u_cap (
        .clk(clk), .rst(rst), .bus(mq_bus), .low_stb(low_latch),
        .start_stb(start), .wide(wide_mode), .idle(idle),
        .accept(accept), .key_q(key_q), .wide_q(wide_q)
    );

    kmatch_table #(.DEPTH(DEPTH)) u_tbl (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_key(ld_key),
        .ld_vpath(ld_vpath), .ld_data(ld_data), .srch_key(key_q),
        .srch_wide(wide_q), .hit(hit), .hit_vpath(hit_vpath), .hit_data(hit_data)
    );

    kmatch_seq #(.LAT(LAT)) u_seq (
        .clk(clk), .rst(rst), .accept(accept), .hit(hit), .hit_vpath(hit_vpath),
        .hit_data(hit_data), .atm(atm_mode), .oe(out_en), .idle(idle),
        .done(match_done), .found(match_found), .vpath(match_vpath),
        .out_data(match_data)
    );
endmodule

// File: tb/keymatch_engine_tb_top.sv
module keymatch_engine_tb_top;
    localparam int DEPTH = 8;
    localparam int LAT   = 3;

    typedef struct {
        int          cyc;
        logic        found;
        logic        vp;
        logic [15:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mq_bus = '0;
    logic        low_latch = 1'b0, start = 1'b0, wide_mode = 1'b0, atm_mode = 1'b0;
    logic        out_en = 1'b1, ld_en = 1'b0, ld_vpath = 1'b0;
    logic [63:0] ld_key = '0;
    logic [15:0] ld_data = '0;
    logic        match_done, match_found, match_vpath;
    logic [15:0] match_data;

    int   cyc = 0, n_checks = 0, n_err = 0, n_done = 0, n_push = 0;
    bit   finished = 0;
    exp_t sb[$];

    logic        m_valid [DEPTH];
    logic [63:0] m_key   [DEPTH];
    logic        m_vp    [DEPTH];
    logic [15:0] m_data  [DEPTH];

    keymatch_engine #(.DEPTH(DEPTH), .LAT(LAT)) dut_i (
        .clk(clk), .rst(rst), .mq_bus(mq_bus), .low_latch(low_latch), .start(start),
        .wide_mode(wide_mode), .atm_mode(atm_mode), .out_en(out_en), .ld_en(ld_en),
        .ld_key(ld_key), .ld_vpath(ld_vpath), .ld_data(ld_data),
        .match_done(match_done), .match_found(match_found),
        .match_vpath(match_vpath), .match_data(match_data)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 1'b0; m_key[i] = '0; m_vp[i] = 1'b0; m_data[i] = '0;
        end
    endtask

    task automatic load(input logic [63:0] k, input logic vp, input logic [15:0] d);
        int slot;
        slot = -1;
        for (int i = DEPTH - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
        for (int i = DEPTH - 1; i >= 0; i--) if (m_valid[i] && m_key[i] == k) slot = i;
        if (slot >= 0) begin
            m_valid[slot] = 1'b1; m_key[slot] = k; m_vp[slot] = vp; m_data[slot] = d;
        end
        @(negedge clk);
        ld_en = 1'b1; ld_key = k; ld_vpath = vp; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    function automatic exp_t model_lookup(input logic [63:0] k, input logic wide,
                                          input logic atm, input string tag);
        exp_t e;
        logic [63:0] m;
        m = wide ? '1 : 64'h0000_0000_FFFF_FFFF;
        e.found = 1'b0; e.vp = 1'b0; e.data = '0; e.tag = tag; e.cyc = 0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (m_valid[i] && ((m_key[i] ^ k) & m) == '0) begin
                e.found = 1'b1; e.vp = atm && m_vp[i]; e.data = m_data[i];
            end
        end
        return e;
    endfunction

    // style 0: strobe two cycles, key valid for one; style 1: strobe one cycle, key held two
    task automatic lookup(input logic [31:0] hi, input logic [31:0] lo, input logic wide,
                          input logic atm, input int style, input string tag);
        exp_t e;
        @(negedge clk);
        wide_mode = wide; atm_mode = atm;
        if (wide) begin
            low_latch = 1'b1; mq_bus = lo;
            @(negedge clk);
            low_latch = 1'b0; mq_bus = hi;
        end else begin
            mq_bus = lo;
        end
        e = model_lookup({hi, lo}, wide, atm, tag);
        e.cyc = cyc + 1 + LAT;
        sb.push_back(e);
        n_push++;
        start = 1'b1;
        @(negedge clk);
        if (style == 0) begin
            mq_bus = 32'hA5A5_5A5A;
            @(negedge clk);
            start = 1'b0;
        end else begin
            start = 1'b0;
            @(negedge clk);
        end
        repeat (LAT + 2) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && match_done) begin
            exp_t e;
            n_done++;
            if (sb.size() == 0) begin
                n_checks++; n_err++;
                $display("FAIL R8: actual=unexpected completion expected=none");
            end else begin
                e = sb.pop_front();
                check({e.tag, " R3 latency"}, 64'(cyc), 64'(e.cyc));
                check({e.tag, " R4 found"}, 64'(match_found), 64'(e.found));
                check({e.tag, " R5 vpath"}, 64'(match_vpath), 64'(e.vp));
                check({e.tag, " R4 data"}, 64'(match_data), 64'(e.data));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset done", 64'(match_done), 64'd0);
        check("R10 reset found", 64'(match_found), 64'd0);
        check("R10 reset vpath", 64'(match_vpath), 64'd0);
        check("R10 reset data", 64'(match_data), 64'd0);
        lookup(32'h0, 32'h0, 1'b0, 1'b0, 1, "R10 empty table");

        load(64'h0000_0000_1111_1111, 1'b0, 16'hA001);
        load(64'h0000_0000_2222_2222, 1'b1, 16'hA002);
        load(64'hDEAD_BEEF_3333_3333, 1'b1, 16'hA003);
        load(64'h1234_5678_3333_3333, 1'b0, 16'hA004);

        lookup(32'h0, 32'h1111_1111, 1'b0, 1'b0, 1, "R1 narrow hit");
        lookup(32'h0, 32'h2222_2222, 1'b0, 1'b0, 0, "R5 atm off");
        lookup(32'h0, 32'h2222_2222, 1'b0, 1'b1, 0, "R5 atm on");
        lookup(32'h0, 32'h7777_7777, 1'b0, 1'b1, 1, "R4 miss");
        lookup(32'h0, 32'h3333_3333, 1'b0, 1'b1, 1, "R9 lowest index");
        lookup(32'hDEAD_BEEF, 32'h3333_3333, 1'b1, 1'b1, 0, "R2 wide upper A");
        lookup(32'h1234_5678, 32'h3333_3333, 1'b1, 1'b1, 1, "R2 wide upper B");
        lookup(32'h0, 32'h1111_1111, 1'b1, 1'b0, 0, "R2 wide zero upper");
        lookup(32'hFFFF_FFFF, 32'h1111_1111, 1'b1, 1'b0, 1, "R2 wide miss");

        // oe gating on the last hit
        lookup(32'h0, 32'h1111_1111, 1'b0, 1'b0, 1, "R6 setup");
        out_en = 1'b0;
        @(negedge clk);
        check("R6 oe low", 64'(match_data), 64'd0);
        out_en = 1'b1;
        @(negedge clk);
        check("R6 oe high", 64'(match_data), 64'hA001);

        // replacement on equal key
        load(64'h1234_5678_3333_3333, 1'b1, 16'hB004);
        lookup(32'h1234_5678, 32'h3333_3333, 1'b1, 1'b1, 0, "R7 replace");

        // start while busy is dropped
        @(negedge clk);
        wide_mode = 1'b0; atm_mode = 1'b0; mq_bus = 32'h1111_1111;
        begin
            exp_t e;
            e = model_lookup({32'h0, 32'h1111_1111}, 1'b0, 1'b0, "R8 busy first");
            e.cyc = cyc + 1 + LAT;
            sb.push_back(e);
            n_push++;
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        mq_bus = 32'h2222_2222; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (LAT + 4) @(negedge clk);
        check("R8 one completion per accept", 64'(n_done), 64'(n_push));

        // fill the table, then overflow
        load(64'h0000_0000_5555_0004, 1'b0, 16'hC004);
        load(64'h0000_0000_5555_0005, 1'b0, 16'hC005);
        load(64'h0000_0000_5555_0006, 1'b0, 16'hC006);
        load(64'hAAAA_0000_5555_0007, 1'b1, 16'hC007);
        load(64'h0000_0000_0000_9999, 1'b0, 16'hC008);
        lookup(32'h0, 32'h0000_9999, 1'b0, 1'b0, 1, "R7 full ignored");
        lookup(32'hAAAA_0000, 32'h5555_0007, 1'b1, 1'b1, 0, "R7 last slot");

        // reset empties the table
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        lookup(32'h0, 32'h1111_1111, 1'b0, 1'b0, 1, "R10 after reset");

        repeat (4) @(negedge clk);
        check("R3 scoreboard drained", 64'(sb.size()), 64'd0);
        check("R8 total completions", 64'(n_done), 64'(n_push));
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule